// File: doc/BRIEF.md
# Noise-Masked Shift-Register Word Generator

This block builds 16-bit random words for a low-cost identification tag. A 16-stage linear feedback shift register supplies a pseudorandom bit stream. An external physical noise source supplies one bit per word, which arrives here as a plain input. When a word is requested, that noise bit is captured once. It is then XORed onto each of the 16 shift-register bits that make up the word, so every bit of the linear sequence is hidden behind a bit the register cannot predict.

A word is assembled serially, one bit per clock, over 16 clocks. After the 16th bit the finished word appears on the output together with a one-cycle valid strobe. The word stays on the output until the next word completes. Software-free seeding is possible through a load port. The register only advances while a word is being assembled, so a bench or a host can predict the unmasked sequence exactly from the seed.

Top module: `noise_lfsr_wordgen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `word_out` becomes 0, `word_valid` becomes 0 and the register state becomes 16'hACE1.
- R2: The register shifts toward bit 15, its output is bit 15, and the feedback into bit 0 is bit15 ^ bit13 ^ bit12 ^ bit10 (polynomial x^16+x^14+x^13+x^11+1). It steps once per clock during assembly only.
- R3: `noise_bit` is sampled at the edge that accepts `start`. Each word bit equals the register output bit XORed with that sampled value for all 16 bits.
- R4: When `start` is accepted at edge E0, `word_valid` is high for exactly one cycle, following edge E16, and low after every edge from E1 to E15.
- R5: Bits enter MSB first: the first generated bit lands in `word_out[15]` and the 16th in `word_out[0]`.
- R6: `word_out` holds its value from one completion until the next one.
- R7: `seed_load` while idle writes `seed_value` into the register; an all-zero value is written as 16'h0001.
- R8: `seed_load` while a word is being assembled is ignored. The word and the sequence continue unchanged.
- R9: `start` while a word is being assembled, including at the 16th edge, is ignored. It neither restarts the word nor resamples `noise_bit`.
- R10: `seed_load` and `start` at the same idle edge load the seed first, and the word is drawn from the new seed.
- R11: Successive words continue the register sequence from where the previous word stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| seed_load | input | 1 | Write `seed_value` into the register when idle |
| seed_value | input | 16 | Seed to load |
| start | input | 1 | Request a new word |
| noise_bit | input | 1 | External true-random bit |
| word_out | output | 16 | Last completed word |
| word_valid | output | 1 | One-cycle strobe when `word_out` is updated |

## Verification
Seed loading and word start can occur at the same edge. The bench provokes this twice. In one case both are raised together while idle, and the resulting word must equal the new seed XOR the noise mask. In the other case a seed write of 16'hFFFF lands in the middle of a word, and both the word in progress and the following word must match the unchanged sequence. A start held high through the assembly of a word, including the final edge, is judged by unchanged strobe timing and an unchanged mask.

// File: rtl/nlw_pkg.sv
// Package: shared constants for the noise-masked word generator.
// Assumes a Fibonacci register whose taps are given as a bit mask.
package nlw_pkg;
    localparam int          WORD_W       = 16;
    localparam logic [15:0] TAP_MASK     = 16'hB400;   // bits 15,13,12,10
    localparam logic [15:0] RESET_SEED   = 16'hACE1;
    localparam int          CNT_W        = $clog2(WORD_W);
endpackage

// File: rtl/nlw_lfsr.sv
// Module: Fibonacci shift register with guarded seed load.
// Shifts toward the MSB; the MSB is the output and the feedback enters the LSB.
// Assumes load_en and step_en are never high together.
module nlw_lfsr #(
    parameter int             W     = 16,
    parameter logic [W-1:0]   TAPS  = 16'hB400,
    parameter logic [W-1:0]   INIT  = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         step_en,
    output logic         out_bit
);
    localparam logic [W-1:0] NONZERO = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] state;
    logic         fb;

    // Feedback: parity of the tapped stages.
    always_comb begin
        fb = ^(state & TAPS);
    end

    // Register update: reset, seed load, or one step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= INIT;
        end else if (load_en) begin
            state <= (load_val == '0) ? NONZERO : load_val;
        end else if (step_en) begin
            state <= {state[W-2:0], fb};
        end
    end

    assign out_bit = state[W-1];

    // R7: register is never all zero
    a_r7_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);
    // R7: zero seed is replaced by one
    a_r7_zero_seed: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && load_val == '0) |=> state == NONZERO);
    // R2: register holds when neither loading nor stepping
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !step_en) |=> $stable(state));
endmodule

// File: rtl/nlw_sequencer.sv
// Module: word sequencer. Accepts a start when idle, captures the noise bit,
// and counts the clocks of one word.
// Assumes W is a power of two so the counter wraps naturally.
module nlw_sequencer #(
    parameter int W     = 16,
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic noise_bit,
    output logic active,
    output logic last,
    output logic mask
);
    logic [CNT_W-1:0] cnt;
    logic             accept;

    // A start is honoured only while no word is in progress.
    always_comb begin
        accept = start && !active;
        last   = active && (cnt == CNT_W'(W - 1));
    end

    // Assembly state: busy flag, bit counter and captured mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            mask   <= 1'b0;
        end else if (accept) begin
            active <= 1'b1;
            cnt    <= '0;
            mask   <= noise_bit;
        end else if (active) begin
            cnt    <= cnt + 1'b1;
            if (last) begin
                active <= 1'b0;
            end
        end
    end

    // R3: the mask does not change within a word
    a_r3_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> $stable(mask));
    // R9: a start during assembly does not restart the count
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !last && start) |=> (cnt == $past(cnt) + 1'b1));
    // R4: after the last bit the sequencer is idle
    a_r4_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !active);
endmodule

// File: rtl/nlw_shifter.sv
// Module: serial collector. Shifts masked bits in MSB first and publishes
// the completed word with a one-cycle strobe.
// Assumes shift_en is high for exactly W consecutive cycles per word.
module nlw_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         done,
    input  logic         bit_in,
    output logic [W-1:0] word_out,
    output logic         word_valid
);
    logic [W-1:0] acc;

    // Collect bits; on the final bit publish the word and pulse valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc        <= '0;
            word_out   <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= shift_en && done;
            if (shift_en) begin
                acc <= {acc[W-2:0], bit_in};
                if (done) begin
                    word_out <= {acc[W-2:0], bit_in};
                end
            end
        end
    end

    // R4: the strobe lasts one cycle
    a_r4_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);
    // R6: the word holds between strobes
    a_r6_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> $stable(word_out));
endmodule

// File: rtl/noise_lfsr_wordgen.sv
// Module: top of the noise-masked word generator. Ties the register,
// the sequencer and the collector together.
// Assumes noise_bit is already synchronous to clk.
module noise_lfsr_wordgen
    import nlw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed_load,
    input  logic [WORD_W-1:0] seed_value,
    input  logic              start,
    input  logic              noise_bit,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid
);
    logic active;
    logic last;
    logic mask;
    logic lfsr_bit;
    logic load_ok;
    logic masked_bit;

    // Seed writes are honoured only while idle; masked bit feeds the collector.
    always_comb begin
        load_ok    = seed_load && !active;
        masked_bit = lfsr_bit ^ mask;
    end

    nlw_sequencer #(.W(WORD_W), .CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .noise_bit (noise_bit),
        .active    (active),
        .last      (last),
        .mask      (mask)
    );

    nlw_lfsr #(.W(WORD_W), .TAPS(TAP_MASK), .INIT(RESET_SEED)) u_lfsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_ok),
        .load_val (seed_value),
        .step_en  (active),
        .out_bit  (lfsr_bit)
    );

    nlw_shifter #(.W(WORD_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en   (active),
        .done       (last),
        .bit_in     (masked_bit),
        .word_out   (word_out),
        .word_valid (word_valid)
    );

    // R8: a seed write during assembly never reaches the register
    a_r8_no_busy_load: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> !load_ok);
endmodule

// File: tb/noise_lfsr_wordgen_bench.sv
`timescale 1ns/1ps
module noise_lfsr_wordgen_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        seed_load;
    logic [15:0] seed_value;
    logic        start;
    logic        noise_bit;
    logic [15:0] word_out;
    logic        word_valid;

    int checks = 0;
    int errors = 0;
    logic [15:0] m_s;
    logic [15:0] last_word;
    bit          done_flag = 1'b0;

    always #2 clk = ~clk;

    noise_lfsr_wordgen u_noise_lfsr_wordgen (
        .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_value(seed_value),
        .start(start), .noise_bit(noise_bit), .word_out(word_out), .word_valid(word_valid)
    );

    function automatic logic [15:0] step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One word: optional seed with the start, optional busy-time start / seed noise.
    task automatic run_word(input logic nb, input logic ld, input logic [15:0] sv,
                            input logic busy_start, input logic busy_seed, input string req);
        logic [15:0] exp;
        bit early;
        @(negedge clk);
        seed_load = ld; seed_value = sv; start = 1'b1; noise_bit = nb;
        if (ld) m_s = (sv == 16'h0) ? 16'h0001 : sv;
        for (int k = 0; k < 16; k++) begin
            exp[15-k] = m_s[15] ^ nb;
            m_s = step(m_s);
        end
        @(negedge clk);
        noise_bit = ~nb;
        seed_value = 16'hFFFF;
        early = 1'b0;
        for (int i = 1; i <= 16; i++) begin
            start     = busy_start && (i >= 2);
            seed_load = busy_seed && (i == 8);
            @(negedge clk);
            if (i < 16 && word_valid) early = 1'b1;
        end
        chk({req, " R4 no early valid"}, {15'd0, early}, 16'd0);
        chk({req, " R4 valid at 16th"}, {15'd0, word_valid}, 16'd1);
        chk({req, " R3 R5 word"}, word_out, exp);
        start = 1'b0; seed_load = 1'b0;
        @(negedge clk);
        chk({req, " R4 one-cycle valid"}, {15'd0, word_valid}, 16'd0);
        chk({req, " R6 word held"}, word_out, exp);
        last_word = exp;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; seed_load = 1'b0; seed_value = '0; start = 1'b0; noise_bit = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 word_out reset", word_out, 16'h0);
        chk("R1 valid reset", {15'd0, word_valid}, 16'd0);
        rst_n = 1'b1;
        m_s = 16'hACE1;
    endtask

    task automatic t_hold;
        repeat (6) @(negedge clk);
        chk("R6 idle hold", word_out, last_word);
        chk("R6 no stray valid", {15'd0, word_valid}, 16'd0);
    endtask

    task automatic t_seed_idle;
        @(negedge clk);
        seed_load = 1'b1; seed_value = 16'h1234;
        @(negedge clk);
        seed_load = 1'b0;
        m_s = 16'h1234;
        run_word(1'b0, 1'b0, 16'h0, 1'b0, 1'b0, "R7 seed 1234");
        chk("R7 seed word", last_word, 16'h1234);
        run_word(1'b1, 1'b1, 16'h0000, 1'b0, 1'b0, "R7 zero seed");
        chk("R7 zero seed word", last_word, 16'hFFFE);
    endtask

    initial begin
        t_reset();
        run_word(1'b0, 1'b0, 16'h0, 1'b0, 1'b0, "R1 R2 first");
        chk("R1 R2 first word from reset seed", last_word, 16'hACE1);
        run_word(1'b1, 1'b0, 16'h0, 1'b0, 1'b0, "R3 R11 second");
        run_word(1'b0, 1'b0, 16'h0, 1'b0, 1'b0, "R11 third");
        t_hold();
        t_seed_idle();
        run_word(1'b0, 1'b0, 16'h0, 1'b0, 1'b1, "R8 busy seed");
        run_word(1'b1, 1'b0, 16'h0, 1'b0, 1'b0, "R8 after busy seed");
        run_word(1'b0, 1'b0, 16'h0, 1'b1, 1'b0, "R9 busy start");
        run_word(1'b1, 1'b0, 16'h0, 1'b0, 1'b0, "R9 after busy start");
        run_word(1'b1, 1'b1, 16'hBEEF, 1'b0, 1'b0, "R10 seed with start");
        chk("R10 new seed word", last_word, 16'h4110);
        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done_flag) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule